// File: doc/BRIEF.md
# External Interrupt Request Controller

This block takes one active-low external interrupt pin, brings it into the clock domain through a two-stage synchronizer, and turns a falling edge into a pending request held in a latch. If level sensitivity is selected, a pin that stays low also sets the latch. The latch drives an interrupt request toward the CPU unless a mask bit blocks it. Software sees the block as one 8-bit status and control register on a small bus with address, write strobe, write data and combinational read data. The register address is a parameter, so several copies can sit side by side.

The latch is a two-state machine. The states are `ST_IDLE` (nothing pending) and `ST_PENDING` (request latched). There are two transitions. The `set` transition goes from `ST_IDLE` to `ST_PENDING` on a synchronized falling edge, or on a synchronized low pin when level mode is on. The `clear` transition goes from `ST_PENDING` to `ST_IDLE` when an acknowledge write is allowed and no set event occurs in the same cycle. A set event has priority over a clear.

The clear is gated while a debug break is in progress. While the break input is high, an acknowledge write only takes effect if the break-clear-enable input is high.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the register reads 0x00 and `irq_req` is low.
- R2: The read data layout is: bit 3 = pending flag, bit 1 = mask, bit 0 = mode. Bit 2 (acknowledge) and bits 7..4 always read 0.
- R3: In edge mode (bit 0 = 0), a synchronized falling edge on `irq_pin_n` sets the pending flag. A pin held low after an acknowledge does not set the flag again.
- R4: In level mode (bit 0 = 1), the flag stays set, or sets again after an acknowledge, for as long as the synchronized pin is low.
- R5: Writing 1 to bit 2 outside a break clears the pending flag. The clear is visible in the next cycle.
- R6: `irq_req` is high exactly when the flag is set and mask bit 1 is 0. The flag reads the same whatever the mask is.
- R7: While `brk_active` is 1 and `brk_clr_en` is 0, an acknowledge write leaves the pending flag unchanged.
- R8: While `brk_clr_en` is 1, an acknowledge write clears the flag even during a break. The flag stays clear after the break ends.
- R9: A write to an address other than `REG_ADDR` changes nothing. A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| brk_active | input | 1 | High while the CPU is in a debug break |
| brk_clr_en | input | 1 | Allows acknowledge writes during a break |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
The assertions assume that the break inputs and bus signals are synchronous to `clk`. They also assume that a write strobe lasts one cycle with a stable address and data. The bench drives every bus and break input at the falling clock edge, and each write strobe is held for exactly one cycle. Pin changes are held for at least three cycles, so every edge passes through the synchronizer before the bench samples the result.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } irq_state_e;

    localparam int REG_W    = 8;
    localparam int MODE_BIT = 0;
    localparam int MASK_BIT = 1;
    localparam int ACK_BIT  = 2;
    localparam int PEND_BIT = 3;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_low,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_n};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign pin_low = ~chain_q[STAGES-1];
    assign fall    = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/eirq_latch_fsm.sv
module eirq_latch_fsm
    import eirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic pin_low,
    input  logic level_mode,
    input  logic ack_wr,
    input  logic brk_active,
    input  logic brk_clr_en,
    output logic pending
);
    irq_state_e state_q, state_d;
    logic       set_evt, clr_evt;

    assign set_evt = fall | (level_mode & pin_low);
    assign clr_evt = ack_wr & (~brk_active | brk_clr_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (set_evt) state_d = ST_PENDING;
            ST_PENDING: if (clr_evt && !set_evt) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == ST_PENDING);
    end
endmodule

// File: rtl/eirq_regif.sv
module eirq_regif
    import eirq_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              pending,
    output logic [REG_W-1:0]  rdata,
    output logic              mask_q,
    output logic              mode_q,
    output logic              ack_wr
);
    logic hit;
    logic unused_wbits;

    assign hit          = (addr == REG_ADDR);
    assign ack_wr       = wr & hit & wdata[ACK_BIT];
    assign unused_wbits = ^{wdata[REG_W-1:PEND_BIT]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
            mode_q <= 1'b0;
        end else if (wr && hit) begin
            mask_q <= wdata[MASK_BIT];
            mode_q <= wdata[MODE_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[PEND_BIT] = pending;
            rdata[MASK_BIT] = mask_q;
            rdata[MODE_BIT] = mode_q;
        end
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h1E,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_pin_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              brk_active,
    input  logic              brk_clr_en,
    output logic              irq_req
);
    logic sync_low, sync_fall;
    logic pend_q, mask_q, mode_q, ack_wr;

    eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (irq_pin_n),
        .pin_low (sync_low),
        .fall    (sync_fall)
    );

    eirq_latch_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall       (sync_fall),
        .pin_low    (sync_low),
        .level_mode (mode_q),
        .ack_wr     (ack_wr),
        .brk_active (brk_active),
        .brk_clr_en (brk_clr_en),
        .pending    (pend_q)
    );

    eirq_regif #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .pending (pend_q),
        .rdata   (bus_rdata),
        .mask_q  (mask_q),
        .mode_q  (mode_q),
        .ack_wr  (ack_wr)
    );

    assign irq_req = pend_q & ~mask_q;
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1E
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              brk_active,
    input logic              brk_clr_en,
    input logic              irq_req,
    input logic              sync_fall,
    input logic              pend_q,
    input logic              mask_q,
    input logic              mode_q,
    input logic              ack_wr
);
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[7:4] == 4'h0) && !bus_rdata[2]);

    assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_fall |=> pend_q);

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !brk_active && !mode_q && !sync_fall) |=> !pend_q);

    assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && mask_q) |-> !irq_req);

    assert_req_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> pend_q);

    assert_brk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && brk_active && !brk_clr_en && pend_q) |=> pend_q);

    assert_brk_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && brk_active && brk_clr_en && !mode_q && !sync_fall) |=> !pend_q);

    assert_miss_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != REG_ADDR) |-> (bus_rdata == 8'h00));
endmodule

bind ext_irq_ctrl eirq_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .brk_active (brk_active),
    .brk_clr_en (brk_clr_en),
    .irq_req    (irq_req),
    .sync_fall  (sync_fall),
    .pend_q     (pend_q),
    .mask_q     (mask_q),
    .mode_q     (mode_q),
    .ack_wr     (ack_wr)
);

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;
    localparam logic [7:0] RA    = 8'h1E;
    localparam logic [7:0] OTHER = 8'h1C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic [7:0] bus_addr = RA;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       brk_active = 1'b0;
    logic       brk_clr_en = 1'b0;
    logic       irq_req;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ext_irq_ctrl #(.ADDR_W(8), .REG_ADDR(RA)) i_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .brk_active(brk_active),
        .brk_clr_en(brk_clr_en), .irq_req(irq_req)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check8(req, bus_rdata, exp);
        bus_addr = RA;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = RA; bus_wdata = 8'h00;
    endtask

    task automatic pin_set(input logic v);
        irq_pin_n = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        read_chk("R1", RA, 8'h00);
        check8("R1", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_edge;
        wr(RA, 8'h00);
        pin_set(1'b0);
        read_chk("R3", RA, 8'h08);
        check8("R3", {7'd0, irq_req}, 8'h01);
        wr(RA, 8'h04);
        read_chk("R5", RA, 8'h00);
        repeat (4) @(negedge clk);
        read_chk("R3", RA, 8'h00);
        pin_set(1'b1);
        read_chk("R3", RA, 8'h00);
    endtask

    task automatic t_level;
        wr(RA, 8'h01);
        read_chk("R2", RA, 8'h01);
        pin_set(1'b0);
        read_chk("R4", RA, 8'h09);
        wr(RA, 8'h05);
        read_chk("R4", RA, 8'h09);
        pin_set(1'b1);
        wr(RA, 8'h05);
        read_chk("R4", RA, 8'h01);
        wr(RA, 8'h00);
    endtask

    task automatic t_mask;
        wr(RA, 8'h02);
        pin_set(1'b0);
        read_chk("R6", RA, 8'h0A);
        check8("R6", {7'd0, irq_req}, 8'h00);
        wr(RA, 8'h00);
        check8("R6", {7'd0, irq_req}, 8'h01);
        wr(RA, 8'h04);
        check8("R6", {7'd0, irq_req}, 8'h00);
        pin_set(1'b1);
    endtask

    task automatic t_break;
        pin_set(1'b0);
        brk_active = 1'b1; brk_clr_en = 1'b0;
        wr(RA, 8'h04);
        read_chk("R7", RA, 8'h08);
        check8("R7", {7'd0, irq_req}, 8'h01);
        brk_clr_en = 1'b1;
        wr(RA, 8'h04);
        read_chk("R8", RA, 8'h00);
        @(negedge clk);
        brk_active = 1'b0; brk_clr_en = 1'b0;
        repeat (2) @(negedge clk);
        read_chk("R8", RA, 8'h00);
        check8("R8", {7'd0, irq_req}, 8'h00);
        pin_set(1'b1);
    endtask

    task automatic t_addr;
        wr(OTHER, 8'h03);
        read_chk("R9", RA, 8'h00);
        pin_set(1'b0);
        wr(OTHER, 8'h04);
        read_chk("R9", RA, 8'h08);
        read_chk("R9", OTHER, 8'h00);
        wr(RA, 8'h04);
        pin_set(1'b1);
        wr(RA, 8'hF7);
        read_chk("R2", RA, 8'h03);
        wr(RA, 8'h00);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_level();
        t_mask();
        t_break();
        t_addr();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule